// File: doc/BRIEF.md
# Serializing Snoop Bus with Dirty-Supply Memory Abort

This block is the shared broadcast bus that sits between a set of private caches and one memory. Caches raise a request carrying a coherence command and a block address. The bus grants one requester at a time and holds that grant until the data for the transaction has been delivered. It then drives the command, address and owner index onto a single set of wires that every agent sees. The order of grants is the one global order in which all read misses, write misses and write-backs take effect. So the first write miss to win the bus invalidates the other copies before any later write to the same block can be seen.

On a read miss or write miss, memory is started in the same cycle as the address broadcast. Every cache other than the requester checks its tags. A fixed number of cycles later the bus samples their supply responses. If any snooping cache claims a dirty copy, the bus aborts the memory access and forwards that cache's block to the requester. Otherwise the memory block is forwarded. A write-back carries a full block straight to memory and needs no snoop.

Top module: `snoop_bus`

## Requirements
- R1: After reset `grant`, `bus_valid`, `mem_req`, `mem_abort` and `resp_valid` are all 0.
- R2: With the round-robin arbiter the search for the next winner starts at the index after the last winner. After reset the previous winner is taken to be N_CACHE-1. If caches 0..3 all request after cache 2 was served, the grants go 3, 0, 1, 2.
- R3: `grant` is zero or one-hot. It stays constant from the cycle it rises up to and including the `resp_valid` cycle. During `resp_valid` it still names the requester.
- R4: The address phase is the first cycle of a grant. In that cycle `bus_valid` is 1, `bus_cmd`/`bus_addr` are the winner's command and address, and `bus_owner` is the winner's index. `snoop_en` has every bit set except the winner's. Command codes are: 2'b01 read miss, 2'b10 write miss, 2'b11 write-back, 2'b00 idle.
- R5: For a miss, `snp_supply` is sampled exactly SNOOP_DLY cycles after the address phase. The requester's own supply bit is ignored.
- R6: If a non-requesting cache supplies at the sample cycle, `mem_abort` is 1 in that cycle. On the next cycle `resp_valid` is 1 with that cache's `snp_data` block and `resp_from_cache` is 1.
- R7: With no supplier, the memory block is returned with `resp_from_cache` 0 and no abort. `resp_valid` comes one cycle after the later of the sample cycle and the `mem_rvalid` cycle. A memory block that arrives before the sample is held until the sample.
- R8: A write-back drives `mem_req` and `mem_we` in the address phase, with `mem_addr`/`mem_wdata` set to the requester's address and block. `resp_valid` follows in the next cycle, and snoop supply is ignored.
- R9: When several non-requesting caches supply, the block of the lowest-indexed one is forwarded.
- R10: Transactions never overlap. `grant` drops the cycle after `resp_valid`, and the next address phase comes after the previous response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | N_CACHE | Per-cache bus request |
| req_cmd | input | 2*N_CACHE | Per-cache command, 2 bits per cache |
| req_addr | input | N_CACHE*ADDR_W | Per-cache block address |
| req_wdata | input | N_CACHE*BLK_W | Per-cache write-back block |
| grant | output | N_CACHE | One-hot grant, held through the data phase |
| bus_valid | output | 1 | Address phase strobe |
| bus_cmd | output | 2 | Broadcast command |
| bus_addr | output | ADDR_W | Broadcast block address |
| bus_owner | output | log2(N_CACHE) | Index of the requester |
| snoop_en | output | N_CACHE | Caches that must snoop this transaction |
| snp_supply | input | N_CACHE | Per-cache dirty-copy supply response |
| snp_data | input | N_CACHE*BLK_W | Per-cache supplied block |
| mem_req | output | 1 | Memory access start |
| mem_we | output | 1 | Memory write (write-back) |
| mem_addr | output | ADDR_W | Memory block address |
| mem_wdata | output | BLK_W | Memory write block |
| mem_abort | output | 1 | Cancel the outstanding memory read |
| mem_rvalid | input | 1 | Memory read block valid |
| mem_rdata | input | BLK_W | Memory read block |
| resp_valid | output | 1 | Data phase complete |
| resp_data | output | BLK_W | Block returned to the requester |
| resp_from_cache | output | 1 | Block came from a snooping cache |

## Verification
The bench builds four caches, a 12-bit address, a 32-bit block, a snoop delay of two cycles and the round-robin arbiter. Four caches are enough to reach a full rotation, a dirty copy held by the requester itself, and two dirty suppliers on either side of the requester. The bench's memory model has a latency that can be changed between tests, set to 1, 2 or 4 cycles. Its block therefore arrives before the snoop sample, in the same cycle as the sample, or after it. This covers the held early block, the same-cycle hand-off and the wait state.

// File: rtl/snoop_bus_pkg.sv
package snoop_bus_pkg;
   typedef enum logic [1:0] {
      CMD_IDLE   = 2'b00,
      CMD_RDMISS = 2'b01,
      CMD_WRMISS = 2'b10,
      CMD_WBACK  = 2'b11
   } bus_cmd_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_SNOOP,
      ST_MWAIT,
      ST_RESP
   } bus_st_e;
endpackage

// File: rtl/snoop_bus_arb.sv
module snoop_bus_arb #(
   parameter int N_REQ = 4,
   parameter bit RR    = 1'b1,
   localparam int IDX_W = $clog2(N_REQ)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_REQ-1:0] req,
   input  logic             accept,
   output logic [N_REQ-1:0] win,
   output logic [IDX_W-1:0] win_idx,
   output logic             any
);
   initial assert (N_REQ >= 2) else $error("snoop_bus_arb: N_REQ must be at least 2");

   assign any = |req;

   generate
      if (RR) begin : g_rr
         logic [IDX_W-1:0] last_q;

         always_comb begin
            int  idx;
            logic found;
            win     = '0;
            win_idx = '0;
            found   = 1'b0;
            for (int k = 0; k < N_REQ; k++) begin
               idx = (int'(last_q) + 1 + k) % N_REQ;
               if (!found && req[idx]) begin
                  found        = 1'b1;
                  win[idx]     = 1'b1;
                  win_idx      = idx[IDX_W-1:0];
               end
            end
         end

         always_ff @(posedge clk) begin
            if (!rst_n)
               last_q <= IDX_W'(N_REQ - 1);
            else if (accept && any)
               last_q <= win_idx;
         end
      end else begin : g_fixed
         always_comb begin
            logic found;
            win     = '0;
            win_idx = '0;
            found   = 1'b0;
            for (int k = 0; k < N_REQ; k++) begin
               if (!found && req[k]) begin
                  found   = 1'b1;
                  win[k]  = 1'b1;
                  win_idx = k[IDX_W-1:0];
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/snoop_bus_srcsel.sv
module snoop_bus_srcsel #(
   parameter int N_SRC = 4,
   parameter int BLK_W = 64
) (
   input  logic [N_SRC-1:0]       supply,
   input  logic [N_SRC-1:0]       mask,
   input  logic [N_SRC*BLK_W-1:0] data,
   output logic                   hit,
   output logic [BLK_W-1:0]       sel_data
);
   logic [N_SRC-1:0] live;

   assign live = supply & mask;
   assign hit  = |live;

   always_comb begin
      sel_data = '0;
      for (int k = N_SRC - 1; k >= 0; k--) begin
         if (live[k]) sel_data = data[k*BLK_W +: BLK_W];
      end
   end
endmodule

// File: rtl/snoop_bus.sv
module snoop_bus
   import snoop_bus_pkg::*;
#(
   parameter int N_CACHE   = 4,
   parameter int ADDR_W    = 16,
   parameter int BLK_W     = 64,
   parameter int SNOOP_DLY = 2,
   parameter bit ARB_RR    = 1'b1,
   localparam int IDX_W    = $clog2(N_CACHE)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [N_CACHE-1:0]       req,
   input  logic [2*N_CACHE-1:0]     req_cmd,
   input  logic [N_CACHE*ADDR_W-1:0] req_addr,
   input  logic [N_CACHE*BLK_W-1:0] req_wdata,
   output logic [N_CACHE-1:0]       grant,
   output logic                     bus_valid,
   output logic [1:0]               bus_cmd,
   output logic [ADDR_W-1:0]        bus_addr,
   output logic [IDX_W-1:0]         bus_owner,
   output logic [N_CACHE-1:0]       snoop_en,
   input  logic [N_CACHE-1:0]       snp_supply,
   input  logic [N_CACHE*BLK_W-1:0] snp_data,
   output logic                     mem_req,
   output logic                     mem_we,
   output logic [ADDR_W-1:0]        mem_addr,
   output logic [BLK_W-1:0]         mem_wdata,
   output logic                     mem_abort,
   input  logic                     mem_rvalid,
   input  logic [BLK_W-1:0]         mem_rdata,
   output logic                     resp_valid,
   output logic [BLK_W-1:0]         resp_data,
   output logic                     resp_from_cache
);
   localparam int CNT_W = $clog2(SNOOP_DLY + 1);

   initial assert (N_CACHE >= 2) else $error("snoop_bus: N_CACHE must be at least 2");
   initial assert (SNOOP_DLY >= 1) else $error("snoop_bus: SNOOP_DLY must be at least 1");
   initial assert (ADDR_W >= 1 && BLK_W >= 1) else $error("snoop_bus: widths must be positive");

   bus_st_e             st_q;
   logic [N_CACHE-1:0]  grant_q;
   logic [IDX_W-1:0]    owner_q;
   bus_cmd_e            cmd_q;
   logic [ADDR_W-1:0]   addr_q;
   logic [BLK_W-1:0]    wdata_q;
   logic [CNT_W-1:0]    cnt_q;
   logic                mem_got_q;
   logic [BLK_W-1:0]    mem_buf_q;
   logic [BLK_W-1:0]    resp_data_q;
   logic                resp_src_q;

   logic [N_CACHE-1:0]  arb_win;
   logic [IDX_W-1:0]    arb_idx;
   logic                arb_any;
   logic                snp_hit;
   logic [BLK_W-1:0]    snp_blk;
   logic                sample;

   snoop_bus_arb #(.N_REQ(N_CACHE), .RR(ARB_RR)) u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (req),
      .accept  (st_q == ST_IDLE),
      .win     (arb_win),
      .win_idx (arb_idx),
      .any     (arb_any)
   );

   snoop_bus_srcsel #(.N_SRC(N_CACHE), .BLK_W(BLK_W)) u_srcsel (
      .supply   (snp_supply),
      .mask     (~grant_q),
      .data     (snp_data),
      .hit      (snp_hit),
      .sel_data (snp_blk)
   );

   assign sample          = (st_q == ST_SNOOP) && (cnt_q == CNT_W'(SNOOP_DLY));
   assign grant           = grant_q;
   assign bus_valid       = (st_q == ST_ADDR);
   assign bus_cmd         = bus_valid ? cmd_q : CMD_IDLE;
   assign bus_addr        = addr_q;
   assign bus_owner       = owner_q;
   assign snoop_en        = bus_valid ? ~grant_q : '0;
   assign mem_req         = bus_valid;
   assign mem_we          = bus_valid && (cmd_q == CMD_WBACK);
   assign mem_addr        = addr_q;
   assign mem_wdata       = wdata_q;
   assign mem_abort       = sample && snp_hit;
   assign resp_valid      = (st_q == ST_RESP);
   assign resp_data       = resp_data_q;
   assign resp_from_cache = resp_src_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         grant_q     <= '0;
         owner_q     <= '0;
         cmd_q       <= CMD_IDLE;
         addr_q      <= '0;
         wdata_q     <= '0;
         cnt_q       <= '0;
         mem_got_q   <= 1'b0;
         mem_buf_q   <= '0;
         resp_data_q <= '0;
         resp_src_q  <= 1'b0;
      end else begin
         unique case (st_q)
            ST_IDLE: if (arb_any) begin
               grant_q <= arb_win;
               owner_q <= arb_idx;
               cmd_q   <= bus_cmd_e'(req_cmd[int'(arb_idx)*2 +: 2]);
               addr_q  <= req_addr[int'(arb_idx)*ADDR_W +: ADDR_W];
               wdata_q <= req_wdata[int'(arb_idx)*BLK_W +: BLK_W];
               st_q    <= ST_ADDR;
            end
            ST_ADDR: begin
               cnt_q     <= CNT_W'(1);
               mem_got_q <= 1'b0;
               if (cmd_q == CMD_WBACK) begin
                  resp_src_q <= 1'b0;
                  st_q       <= ST_RESP;
               end else begin
                  st_q <= ST_SNOOP;
               end
            end
            ST_SNOOP: begin
               if (mem_rvalid && !mem_got_q) begin
                  mem_got_q <= 1'b1;
                  mem_buf_q <= mem_rdata;
               end
               if (sample) begin
                  if (snp_hit) begin
                     resp_data_q <= snp_blk;
                     resp_src_q  <= 1'b1;
                     st_q        <= ST_RESP;
                  end else if (mem_got_q) begin
                     resp_data_q <= mem_buf_q;
                     resp_src_q  <= 1'b0;
                     st_q        <= ST_RESP;
                  end else if (mem_rvalid) begin
                     resp_data_q <= mem_rdata;
                     resp_src_q  <= 1'b0;
                     st_q        <= ST_RESP;
                  end else begin
                     st_q <= ST_MWAIT;
                  end
               end else begin
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
            ST_MWAIT: if (mem_rvalid) begin
               resp_data_q <= mem_rdata;
               resp_src_q  <= 1'b0;
               st_q        <= ST_RESP;
            end
            ST_RESP: begin
               grant_q <= '0;
               st_q    <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assert_grant_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_q));

   assert_grant_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (|grant_q && !resp_valid) |=> (grant_q == $past(grant_q)));

   assert_bus_granted_R3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid |-> ($countones(grant) == 1));

   assert_abort_resp_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_abort |=> (resp_valid && resp_from_cache));

   assert_wb_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_cmd == CMD_WBACK) |=> (resp_valid && !resp_from_cache));

   assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |=> (grant == '0 && !bus_valid));
endmodule

// File: tb/snoop_bus_bench.sv
module snoop_bus_bench;
   localparam int N  = 4;
   localparam int AW = 12;
   localparam int BW = 32;
   localparam int IW = $clog2(N);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  req = '0;
   logic [2*N-1:0] req_cmd = '0;
   logic [N*AW-1:0] req_addr = '0;
   logic [N*BW-1:0] req_wdata = '0;
   logic [N-1:0]  grant;
   logic          bus_valid;
   logic [1:0]    bus_cmd;
   logic [AW-1:0] bus_addr;
   logic [IW-1:0] bus_owner;
   logic [N-1:0]  snoop_en;
   logic [N-1:0]  snp_supply = '0;
   logic [N*BW-1:0] snp_data = '0;
   logic          mem_req, mem_we, mem_abort;
   logic [AW-1:0] mem_addr;
   logic [BW-1:0] mem_wdata;
   logic          mem_rvalid;
   logic [BW-1:0] mem_rdata;
   logic          resp_valid, resp_from_cache;
   logic [BW-1:0] resp_data;

   always #10 clk = ~clk;

   snoop_bus #(.N_CACHE(N), .ADDR_W(AW), .BLK_W(BW), .SNOOP_DLY(2), .ARB_RR(1'b1)) u_snoop_bus (
      .clk(clk), .rst_n(rst_n), .req(req), .req_cmd(req_cmd), .req_addr(req_addr),
      .req_wdata(req_wdata), .grant(grant), .bus_valid(bus_valid), .bus_cmd(bus_cmd),
      .bus_addr(bus_addr), .bus_owner(bus_owner), .snoop_en(snoop_en),
      .snp_supply(snp_supply), .snp_data(snp_data), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_abort(mem_abort),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .resp_valid(resp_valid),
      .resp_data(resp_data), .resp_from_cache(resp_from_cache)
   );

   function automatic logic [BW-1:0] mem_fn(input logic [AW-1:0] a);
      return {20'hBEEF0, a};
   endfunction

   // memory model: fixed latency, cancelled by abort
   int            mem_lat = 4;
   int            m_cnt = 0;
   logic [AW-1:0] m_addr = '0;
   logic [AW-1:0] wr_addr = '0;
   logic [BW-1:0] wr_data = '0;
   int            wr_cnt = 0;

   assign mem_rvalid = (m_cnt == 1);
   assign mem_rdata  = mem_fn(m_addr);

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt <= 0;
      end else if (mem_abort) begin
         m_cnt <= 0;
      end else if (mem_req && !mem_we) begin
         m_cnt  <= mem_lat;
         m_addr <= mem_addr;
      end else if (m_cnt > 0) begin
         m_cnt <= m_cnt - 1;
      end
      if (rst_n && mem_req && mem_we) begin
         wr_addr <= mem_addr;
         wr_data <= mem_wdata;
         wr_cnt  <= wr_cnt + 1;
      end
   end

   // monitor
   int cyc = 0;
   int n_bus = 0, n_resp = 0, n_abort = 0, n_rv = 0;
   int b_cyc [0:63];
   int b_own [0:63];
   int r_cyc [0:63];
   int a_cyc = 0;
   logic [1:0]    b_cmd = '0;
   logic [AW-1:0] b_addr = '0;
   logic [N-1:0]  b_snp = '0;
   logic [BW-1:0] r_data = '0;
   logic          r_src = 1'b0;
   logic [N-1:0]  r_grant = '0;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (rst_n) begin
         if (bus_valid) begin
            b_cyc[n_bus] <= cyc;
            b_own[n_bus] <= int'(bus_owner);
            b_cmd  <= bus_cmd;
            b_addr <= bus_addr;
            b_snp  <= snoop_en;
            n_bus  <= n_bus + 1;
         end
         if (mem_abort) begin
            a_cyc   <= cyc;
            n_abort <= n_abort + 1;
         end
         if (mem_rvalid) n_rv <= n_rv + 1;
         if (resp_valid) begin
            r_cyc[n_resp] <= cyc;
            r_data  <= resp_data;
            r_src   <= resp_from_cache;
            r_grant <= grant;
            n_resp  <= n_resp + 1;
         end
      end
   end

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic post(input int c, input logic [1:0] cmd, input logic [AW-1:0] a,
                       input logic [BW-1:0] wd);
      req_cmd[c*2 +: 2]     = cmd;
      req_addr[c*AW +: AW]  = a;
      req_wdata[c*BW +: BW] = wd;
      req[c]                = 1'b1;
   endtask

   task automatic wait_resps(input int n);
      int target;
      target = n_resp + n;
      while (n_resp < target) begin
         @(negedge clk);
         req = req & ~grant;
      end
      @(negedge clk);
      req = req & ~grant;
   endtask

   task automatic run_one(input int c, input logic [1:0] cmd, input logic [AW-1:0] a,
                          input logic [BW-1:0] wd);
      @(negedge clk);
      post(c, cmd, a, wd);
      wait_resps(1);
   endtask

   task automatic t_reset;
      chk("R1 grant", grant, 0);
      chk("R1 bus_valid", bus_valid, 0);
      chk("R1 mem_req", mem_req, 0);
      chk("R1 mem_abort", mem_abort, 0);
      chk("R1 resp_valid", resp_valid, 0);
   endtask

   task automatic t_read_clean(input int lat, input int exp_gap);
      int ab0;
      int k;
      mem_lat = lat;
      ab0 = n_abort;
      run_one(1, 2'b01, 12'h123, '0);
      k = n_bus - 1;
      chk("R4 cmd", b_cmd, 2'b01);
      chk("R4 addr", b_addr, 12'h123);
      chk("R4 owner", b_own[k], 1);
      chk("R4 snoop_en", b_snp, 4'b1101);
      chk("R7 data", r_data, mem_fn(12'h123));
      chk("R7 src", r_src, 0);
      chk("R7 no abort", n_abort - ab0, 0);
      chk("R7 resp timing", r_cyc[n_resp-1] - b_cyc[k], exp_gap);
      chk("R3 grant at resp", r_grant, 4'b0010);
   endtask

   task automatic t_read_dirty;
      int rv0;
      int k;
      mem_lat = 4;
      rv0 = n_rv;
      snp_supply = 4'b0100;
      snp_data[2*BW +: BW] = 32'hCAFE0002;
      run_one(0, 2'b01, 12'h040, '0);
      k = n_bus - 1;
      chk("R5 abort at sample", a_cyc - b_cyc[k], 2);
      chk("R6 resp timing", r_cyc[n_resp-1] - b_cyc[k], 3);
      chk("R6 data", r_data, 32'hCAFE0002);
      chk("R6 src", r_src, 1);
      repeat (4) @(negedge clk);
      chk("R6 memory cancelled", n_rv - rv0, 0);
      snp_supply = '0;
   endtask

   task automatic t_self_supply;
      int ab0;
      mem_lat = 4;
      ab0 = n_abort;
      snp_supply = 4'b0001;
      snp_data[0 +: BW] = 32'h0BAD0000;
      run_one(0, 2'b01, 12'h077, '0);
      chk("R5 own supply ignored data", r_data, mem_fn(12'h077));
      chk("R5 own supply ignored abort", n_abort - ab0, 0);
      snp_supply = '0;
   endtask

   task automatic t_two_suppliers;
      mem_lat = 4;
      snp_supply = 4'b1010;
      snp_data[1*BW +: BW] = 32'hD1D1_0001;
      snp_data[3*BW +: BW] = 32'hD3D3_0003;
      run_one(0, 2'b01, 12'h0A0, '0);
      chk("R9 lowest supplier", r_data, 32'hD1D1_0001);
      run_one(1, 2'b01, 12'h0A1, '0);
      chk("R9 requester masked", r_data, 32'hD3D3_0003);
      snp_supply = '0;
   endtask

   task automatic t_write_miss;
      int k;
      mem_lat = 2;
      run_one(3, 2'b10, 12'h200, '0);
      k = n_bus - 1;
      chk("R4 wrmiss cmd", b_cmd, 2'b10);
      chk("R7 wrmiss data", r_data, mem_fn(12'h200));
      chk("R7 same-cycle timing", r_cyc[n_resp-1] - b_cyc[k], 3);
      snp_supply = 4'b0001;
      snp_data[0 +: BW] = 32'hF00D0000;
      mem_lat = 4;
      run_one(2, 2'b10, 12'h201, '0);
      chk("R6 wrmiss dirty data", r_data, 32'hF00D0000);
      chk("R6 wrmiss dirty src", r_src, 1);
      snp_supply = '0;
   endtask

   task automatic t_writeback;
      int w0, ab0, k;
      w0 = wr_cnt;
      ab0 = n_abort;
      snp_supply = 4'b1000;
      run_one(2, 2'b11, 12'h3C0, 32'h12345678);
      k = n_bus - 1;
      chk("R8 write count", wr_cnt - w0, 1);
      chk("R8 write addr", wr_addr, 12'h3C0);
      chk("R8 write data", wr_data, 32'h12345678);
      chk("R8 resp timing", r_cyc[n_resp-1] - b_cyc[k], 1);
      chk("R8 no abort", n_abort - ab0, 0);
      snp_supply = '0;
   endtask

   task automatic t_round_robin;
      int k0;
      mem_lat = 1;
      run_one(2, 2'b01, 12'h010, '0);
      @(negedge clk);
      k0 = n_bus;
      for (int c = 0; c < N; c++) post(c, 2'b01, 12'h020 + AW'(c), '0);
      wait_resps(4);
      chk("R2 first", b_own[k0], 3);
      chk("R2 second", b_own[k0+1], 0);
      chk("R2 third", b_own[k0+2], 1);
      chk("R2 fourth", b_own[k0+3], 2);
      for (int j = 1; j < 4; j++)
         chk("R10 no overlap", b_cyc[k0+j] > r_cyc[n_resp-5+j], 1);
      chk("R10 last data", r_data, mem_fn(12'h022));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_read_clean(4, 5);
      t_read_clean(1, 3);
      t_read_dirty();
      t_self_supply();
      t_two_suppliers();
      t_write_miss();
      t_writeback();
      t_round_robin();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL R10 watchdog act=hung exp=done");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule